// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two processor-facing request outputs: a normal interrupt line and a fast interrupt line. Each line can be enabled on its own and inverted when it is active low. It can be captured on its rising active edge or followed as a level, and it is steered to either output. Software programs everything through a small word-addressed register bus. Both processor outputs are also gated by a two-bit global mask.

For the normal interrupt path the controller also provides a vector word. It holds the number of the winning source, which is the pending, enabled, normal-routed source with the smallest programmed priority value. The top bit of the word is set when no such source exists. When an acknowledge mode is switched on, reading the vector also clears the latched request of the source it named. The handler can then identify and acknowledge an interrupt with a single bus read.

Register word addresses: 0 enable, 1 route, 2 invert, 3 level, 4 clear, 5 vector, 6 vector control, 7 global mask, 8 to 15 priority table. Bus reads return data in the same cycle the read strobe is high. Writes and acknowledge side effects take effect at the clock edge that ends that cycle.

Top module: `prio_vic`

## Requirements
- R1: After reset the enable, route, invert, level, vector-control, global-mask and priority registers read 0. The vector (address 5) reads 0x8000_0000. Both outputs are low.
- R2: A source whose bit is 0 in the enable register (address 0) is never reported in the vector and never raises either output.
- R3: Route bit 1 (address 1) sends a source to the normal output and makes it a vector candidate. Route bit 0 sends it to the fast output only, and it is then never reported in the vector.
- R4: Invert bit 1 (address 2) makes the input active low, so an input held at 0 is treated as asserted.
- R5: Among the candidates, the one with the smallest priority value wins, and a tie goes to the lower source number. Priority word 8+w holds source 4w+j in bits 8j+7:8j, and all 8 bits are stored and read back.
- R6: The vector word carries the source number in bits 4:0 and zeros above. Bit 31 is set, with every other bit 0, when no candidate is pending.
- R7: A source with level bit 0 (address 3) latches pending on a rising active edge. The request stays pending after the input returns inactive.
- R8: Writing 1s to the clear register (address 4) drops the latched requests of those sources. Writing 0s leaves them untouched.
- R9: When bit 31 of vector control (address 6) is 1, a vector read that returns a valid source clears that source's latched request. When the bit is 0, vector reads have no side effect.
- R10: A source with level bit 1 is pending exactly while its input is active. Neither a clear write nor an acknowledging vector read removes it while it stays active.
- R11: Global mask bit 0 (address 7) gates the normal output and bit 1 gates the fast output. Each output is registered and rises one clock after its pending condition appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt request lines, already synchronous to clk |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the acknowledge side effect) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The checker assumes the request lines are already synchronous to the clock. It also assumes that a source being acknowledged by a vector read does not present a fresh active edge in that same cycle. A new edge there would legitimately set the request again, because setting wins over clearing. The stimulus changes request lines only at falling clock edges. During an acknowledging read it holds every edge-mode line steady. All bus cycles last a single clock, with one strobe at a time.

// File: rtl/pic_pkg.sv
// Shared definitions for the prioritized vectored interrupt controller:
// register word addresses and fixed bit positions in the bus words.
package pic_pkg;
    localparam int REG_ADDR_W   = 5;
    localparam int BUS_W        = 32;
    localparam int PRIO_LANE    = 8;   // bits reserved per source in a priority word
    localparam int VEC_NONE_BIT = 31;  // vector word: no valid source
    localparam int ACK_MODE_BIT = 31;  // vector control: read acknowledges

    typedef logic [REG_ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t A_ENABLE = 5'd0;
    localparam reg_addr_t A_ROUTE  = 5'd1;
    localparam reg_addr_t A_INVERT = 5'd2;
    localparam reg_addr_t A_LEVEL  = 5'd3;
    localparam reg_addr_t A_CLEAR  = 5'd4;
    localparam reg_addr_t A_VECTOR = 5'd5;
    localparam reg_addr_t A_VCTL   = 5'd6;
    localparam reg_addr_t A_GMASK  = 5'd7;
    localparam reg_addr_t A_PRIO0  = 5'd8;
endpackage

// File: rtl/pic_src_cell.sv
// Per-source request capture.
// Inverts the raw line when asked, then either follows it (level mode) or
// latches its rising active edge until a clear pulse (edge mode).
// Assumes raw_i is synchronous to clk. A set in the same cycle as a clear wins.
module pic_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic invert_i,
    input  logic level_i,
    input  logic clr_i,
    output logic pend_o
);
    logic active;
    logic active_prev;
    logic latched;

    assign active = raw_i ^ invert_i;

    // Remember the previous active value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_prev <= 1'b0;
        else        active_prev <= active;
    end

    // Latch edges in edge mode; hold nothing while in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       latched <= 1'b0;
        else if (level_i) latched <= 1'b0;
        else              latched <= (latched & ~clr_i) | (active & ~active_prev);
    end

    assign pend_o = level_i ? active : latched;
endmodule

// File: rtl/pic_arbiter.sv
// Priority arbiter over the normal-interrupt candidates.
// Picks the request with the smallest priority value; ties go to the
// lower index because only a strictly smaller value displaces the holder.
// Purely combinational; depth grows linearly with N_SRC.
module pic_arbiter #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 8,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             req_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                         valid_o,
    output logic [ID_W-1:0]              id_o
);
    logic [PRIO_W-1:0] best_prio;

    // Scan sources in ascending order, keeping the best seen so far.
    always_comb begin
        valid_o   = 1'b0;
        id_o      = '0;
        best_prio = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i] && (!valid_o || (prio_i[i] < best_prio))) begin
                valid_o   = 1'b1;
                id_o      = ID_W'(i);
                best_prio = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/pic_regs.sv
// Register file and bus decode.
// Holds the configuration registers and priority table, returns read data
// combinationally, and produces per-source clear pulses from clear-register
// writes and from acknowledging vector reads. Assumes single-cycle strobes.
module pic_regs
    import pic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 8,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [REG_ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]             bus_wdata,
    output logic [BUS_W-1:0]             bus_rdata,
    input  logic                         vec_valid,
    input  logic [ID_W-1:0]              vec_id,
    output logic [N_SRC-1:0]             en_o,
    output logic [N_SRC-1:0]             route_o,
    output logic [N_SRC-1:0]             invert_o,
    output logic [N_SRC-1:0]             level_o,
    output logic [N_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [1:0]                   gmask_o,
    output logic [N_SRC-1:0]             clr_o,
    output logic                         ack_fire_o
);
    localparam int PRIO_WORDS = (N_SRC + 3) / 4;
    localparam logic [N_SRC-1:0] ONE_HOT0 = N_SRC'(1);

    logic wr_hit, rd_hit, prio_sel, ack_mode;
    int   word_idx;

    assign wr_hit = bus_sel & bus_wr;
    assign rd_hit = bus_sel & bus_rd;

    // Decode which priority word, if any, the address points at.
    always_comb begin
        word_idx = int'(bus_addr) - int'(A_PRIO0);
        prio_sel = (word_idx >= 0) && (word_idx < PRIO_WORDS);
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o     <= '0;
            route_o  <= '0;
            invert_o <= '0;
            level_o  <= '0;
            gmask_o  <= '0;
            ack_mode <= 1'b0;
        end else if (wr_hit) begin
            case (bus_addr)
                A_ENABLE: en_o     <= bus_wdata[N_SRC-1:0];
                A_ROUTE:  route_o  <= bus_wdata[N_SRC-1:0];
                A_INVERT: invert_o <= bus_wdata[N_SRC-1:0];
                A_LEVEL:  level_o  <= bus_wdata[N_SRC-1:0];
                A_VCTL:   ack_mode <= bus_wdata[ACK_MODE_BIT];
                A_GMASK:  gmask_o  <= bus_wdata[1:0];
                default:  ;
            endcase
        end
    end

    // Priority table writes, one lane per source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_o <= '0;
        end else if (wr_hit && prio_sel) begin
            for (int k = 0; k < N_SRC; k++) begin
                if ((k / 4) == word_idx)
                    prio_o[k] <= bus_wdata[(k % 4) * PRIO_LANE +: PRIO_W];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: bus_rdata[N_SRC-1:0] = en_o;
            A_ROUTE:  bus_rdata[N_SRC-1:0] = route_o;
            A_INVERT: bus_rdata[N_SRC-1:0] = invert_o;
            A_LEVEL:  bus_rdata[N_SRC-1:0] = level_o;
            A_VECTOR: begin
                bus_rdata[ID_W-1:0]     = vec_id & {ID_W{vec_valid}};
                bus_rdata[VEC_NONE_BIT] = ~vec_valid;
            end
            A_VCTL:   bus_rdata[ACK_MODE_BIT] = ack_mode;
            A_GMASK:  bus_rdata[1:0] = gmask_o;
            default: begin
                for (int k = 0; k < N_SRC; k++) begin
                    if (prio_sel && ((k / 4) == word_idx))
                        bus_rdata[(k % 4) * PRIO_LANE +: PRIO_W] = prio_o[k];
                end
            end
        endcase
    end

    // Clear pulses: write-one-to-clear plus acknowledge of the returned vector.
    always_comb begin
        ack_fire_o = rd_hit && (bus_addr == A_VECTOR) && ack_mode && vec_valid;
        clr_o      = '0;
        if (wr_hit && (bus_addr == A_CLEAR)) clr_o = bus_wdata[N_SRC-1:0];
        if (ack_fire_o)                      clr_o = clr_o | (ONE_HOT0 << vec_id);
    end
endmodule

// File: rtl/prio_vic.sv
// Top of the prioritized vectored interrupt controller.
// Instantiates one capture cell per source, the register file and the
// normal-path arbiter, and registers the two processor request outputs.
// Assumes src_i is already synchronous to clk.
module prio_vic
    import pic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 8,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      src_i,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  irq_o,
    output logic                  fiq_o
);
    logic [N_SRC-1:0]             en, route, invert, level, pend, clr;
    logic [N_SRC-1:0]             irq_req, fiq_req;
    logic [N_SRC-1:0][PRIO_W-1:0] prio;
    logic [1:0]                   gmask;
    logic                         vec_valid, ack_fire;
    logic [ID_W-1:0]              vec_id;

    pic_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .vec_valid  (vec_valid),
        .vec_id     (vec_id),
        .en_o       (en),
        .route_o    (route),
        .invert_o   (invert),
        .level_o    (level),
        .prio_o     (prio),
        .gmask_o    (gmask),
        .clr_o      (clr),
        .ack_fire_o (ack_fire)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        pic_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (src_i[g]),
            .invert_i (invert[g]),
            .level_i  (level[g]),
            .clr_i    (clr[g]),
            .pend_o   (pend[g])
        );
    end

    assign irq_req = pend & en & route;
    assign fiq_req = pend & en & ~route;

    pic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .req_i   (irq_req),
        .prio_i  (prio),
        .valid_o (vec_valid),
        .id_o    (vec_id)
    );

    // Register both processor request lines behind the global mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= gmask[0] & (|irq_req);
            fiq_o <= gmask[1] & (|fiq_req);
        end
    end
endmodule

// File: rtl/prio_vic_checker.sv
// Assertion checker for prio_vic, attached by bind.
// Assumes no fresh active edge on a source in the cycle it is acknowledged.
module prio_vic_checker #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 8,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         irq_o,
    input logic                         fiq_o,
    input logic [1:0]                   gmask,
    input logic [N_SRC-1:0]             en,
    input logic [N_SRC-1:0]             route,
    input logic [N_SRC-1:0]             level,
    input logic [N_SRC-1:0]             pend,
    input logic [N_SRC-1:0][PRIO_W-1:0] prio,
    input logic                         vec_valid,
    input logic [ID_W-1:0]              vec_id,
    input logic                         ack_fire
);
    logic [N_SRC-1:0] cand;
    assign cand = pend & en & route;

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(gmask[0]));

    // R11
    fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(gmask[1]));

    // R2
    vec_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (en[vec_id] && route[vec_id] && pend[vec_id]));

    // R3
    vec_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand != '0) |-> vec_valid);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !level[vec_id]) |=> !pend[$past(vec_id)]);

    for (genvar i = 0; i < N_SRC; i++) begin : g_ord
        // R5
        prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_valid && cand[i]) |->
                ((prio[vec_id] < prio[i]) ||
                 ((prio[vec_id] == prio[i]) && (vec_id <= ID_W'(i)))));
    end
endmodule

bind prio_vic prio_vic_checker #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .gmask     (gmask),
    .en        (en),
    .route     (route),
    .level     (level),
    .pend      (pend),
    .prio      (prio),
    .vec_valid (vec_valid),
    .vec_id    (vec_id),
    .ack_fire  (ack_fire)
);

// File: tb/tb_prio_vic.sv
module tb_prio_vic;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] NONE = 32'h8000_0000;

    // Table: {source pattern, expected vector} with priority of source i = 31-i.
    localparam logic [63:0] TV [7] = '{
        {32'h0000_0000, NONE},
        {32'h0000_0001, 32'd0},
        {32'h8000_0001, 32'd31},
        {32'h0001_0100, 32'd16},
        {32'h00F0_0000, 32'd23},
        {32'h0000_0006, 32'd2},
        {32'hFFFF_FFFF, 32'd31}
    };

    prio_vic dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_o", {31'd0, irq_o}, 32'd0);
        check("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
        rd(5'd0, d); check("R1 enable", d, 32'd0);
        rd(5'd7, d); check("R1 gmask", d, 32'd0);
        rd(5'd8, d); check("R1 prio word", d, 32'd0);
        rd(5'd5, d); check("R1 vector", d, NONE);

        // R5 priority lane readback: all 8 bits kept
        wr(5'd9, 32'hA5C3_1E07);
        rd(5'd9, d); check("R5 prio readback", d, 32'hA5C3_1E07);

        // Common setup: all enabled, normal route, level mode, prio 31-i.
        wr(5'd0, 32'hFFFF_FFFF);
        wr(5'd1, 32'hFFFF_FFFF);
        wr(5'd3, 32'hFFFF_FFFF);
        for (int w = 0; w < 8; w++) begin
            logic [31:0] pw;
            for (int j = 0; j < 4; j++) pw[j*8 +: 8] = 8'(31 - (4*w + j));
            wr(5'(8 + w), pw);
        end
        wr(5'd7, 32'd1);

        // R5 R6 R11: table of patterns
        for (int t = 0; t < 7; t++) begin
            set_src(TV[t][63:32]);
            rd(5'd5, d);
            check("R5 R6 table vector", d, TV[t][31:0]);
            check("R11 table irq_o", {31'd0, irq_o}, {31'd0, TV[t][63:32] != 0});
        end

        // R5 tie: equal priorities go to lower number
        for (int w = 0; w < 8; w++) wr(5'(8 + w), 32'h0707_0707);
        set_src(32'h0000_0A00);
        rd(5'd5, d); check("R5 tie", d, 32'd9);

        // R2 enable gating
        wr(5'd0, ~32'h0000_0200);
        rd(5'd5, d); check("R2 masked source skipped", d, 32'd11);
        wr(5'd0, 32'd0);
        idle(2);
        rd(5'd5, d); check("R2 all masked vector", d, NONE);
        check("R2 all masked irq_o", {31'd0, irq_o}, 32'd0);
        wr(5'd0, 32'hFFFF_FFFF);

        // R4 polarity
        set_src(32'd0);
        wr(5'd2, 32'h0000_0008);
        rd(5'd5, d); check("R4 low input active", d, 32'd3);
        set_src(32'h0000_0008);
        rd(5'd5, d); check("R4 high input inactive", d, NONE);
        wr(5'd2, 32'd0);
        set_src(32'd0);

        // R7 edge capture, R9 reads without ack mode have no side effect
        wr(5'd3, ~32'h0000_0020);
        set_src(32'h0000_0020);
        set_src(32'd0);
        idle(2);
        rd(5'd5, d); check("R7 latched after pulse", d, 32'd5);
        check("R11 irq_o from latched edge", {31'd0, irq_o}, 32'd1);
        rd(5'd5, d); check("R9 no ack when mode off", d, 32'd5);

        // R8 clear register
        wr(5'd4, 32'h0000_0010);
        rd(5'd5, d); check("R8 zero bits untouched", d, 32'd5);
        wr(5'd4, 32'h0000_0020);
        rd(5'd5, d); check("R8 cleared by write", d, NONE);

        // R9 acknowledge on read
        wr(5'd6, 32'h8000_0000);
        rd(5'd6, d); check("R9 vctl readback", d, 32'h8000_0000);
        set_src(32'h0000_0020);
        set_src(32'd0);
        idle(2);
        rd(5'd5, d); check("R9 ack read returns", d, 32'd5);
        rd(5'd5, d); check("R9 ack cleared", d, NONE);

        // R10 level source survives ack and clear
        set_src(32'h0000_0080);
        rd(5'd5, d); check("R10 level read", d, 32'd7);
        rd(5'd5, d); check("R10 level after ack", d, 32'd7);
        wr(5'd4, 32'h0000_0080);
        rd(5'd5, d); check("R10 level after clear", d, 32'd7);
        set_src(32'd0);
        rd(5'd5, d); check("R10 level follows input", d, NONE);
        wr(5'd6, 32'd0);

        // R3 R11 routing and global masks
        wr(5'd1, ~32'h0000_1000);
        wr(5'd7, 32'd0);
        set_src(32'h0000_1000);
        idle(2);
        check("R11 fiq masked", {31'd0, fiq_o}, 32'd0);
        wr(5'd7, 32'd2);
        idle(2);
        check("R3 fiq raised", {31'd0, fiq_o}, 32'd1);
        check("R3 irq not raised", {31'd0, irq_o}, 32'd0);
        rd(5'd5, d); check("R3 fast source not in vector", d, NONE);
        wr(5'd7, 32'd1);
        idle(2);
        check("R11 fiq gated off", {31'd0, fiq_o}, 32'd0);
        set_src(32'h0000_3000);
        idle(2);
        check("R3 irq raised", {31'd0, irq_o}, 32'd1);
        rd(5'd5, d); check("R3 normal source in vector", d, 32'd13);
        wr(5'd7, 32'd0);
        idle(2);
        check("R11 irq gated off", {31'd0, irq_o}, 32'd0);

        done = 1'b1;
        finish_run();
    end
endmodule